// File: doc/BRIEF.md
# Serial Configuration Chain Loader

This block holds the programming bits of a small reconfigurable fabric and fills them from a serial bitstream. The storage is split into several equal shift chains. A load rewrites only the chain picked at start, so part of the fabric can be reprogrammed while the others keep their contents. Each chain has two kinds of bit. The low bits are power-on values for a bank of user flip-flops. The high bits drive routing switches.

Two load modes exist. In the clock-driving mode the loader resets an external serial memory and then clocks it one bit at a time. In the follower mode an upstream loader supplies both data and a strobe. Every bit pushed out of the far end of the active chain is sent on a serial output together with a valid strobe, so a second device can be chained behind this one and fed from the same memory. A length value sets how many bits a load takes. When that count is reached the loader raises done and the memory clock stops. A quick-reinit request copies the stored power-on values back into the user flip-flops and leaves the switch bits alone.

Top module: `cfg_chain_loader`

## Requirements
- R1: After reset, done_o, err_o, mem_rst_o, mem_clk_o and sdo_vld_o are low, and sw_close_o and ff_q_o are all zero.
- R2: start_i is taken while the loader is idle or done. Mode code 3'b000 selects the clock-driving load and 3'b111 selects the follower load. Any other code sets err_o, leaves done_o low, causes no memory reset or clock, and keeps the loader idle. A start with a valid code clears err_o.
- R3: A clock-driving load raises mem_rst_o for exactly one cycle. It then sends exactly load_len_i pulses on mem_clk_o. Each pulse is high for one cycle and is followed by at least one low cycle, and mem_rst_o is never high together with mem_clk_o. mem_data_i is sampled in the low cycle just before each pulse, so the k-th bit sampled is memory word k counted from the reset.
- R4: A follower load shifts slave_data_i once for each cycle in which slave_stb_i is high. It drives neither mem_clk_o nor mem_rst_o.
- R5: Each shifted bit enters bit 0 of the selected chain, and every other bit moves up one place. After L loaded bits with L at least CHAIN_LEN, bit i holds stream bit L-1-i. Chains that were not selected keep their contents.
- R6: For every shift, sdo_vld_o is high for one cycle in the following cycle. In that cycle sdo_o carries the bit that was pushed out of position CHAIN_LEN-1 of the selected chain.
- R7: done_o rises once load_len_i bits have been shifted and stays high until the next accepted start. A length of 0 completes without any memory clock pulse.
- R8: While done_o is low, sw_close_o and ff_q_o are forced to zero. While done_o is high, sw_close_o[c*SW_BITS+j] equals bit FF_BITS+j of chain c, and a 1 means the switch is closed.
- R9: When done_o rises, ff_q_o[c*FF_BITS+j] is loaded with bit j of chain c for every chain. While done_o is high, ff_we_i writes ff_wdata_i into the flip-flops. reinit_i restores the stored values and leaves sw_close_o unchanged.
- R10: A start_i that arrives during a load is ignored. The load in progress keeps its chain, length and count, and err_o does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a load (one-cycle pulse) |
| mode_i | input | 3 | Load mode code |
| chain_sel_i | input | SEL_W | Chain rewritten by the load |
| load_len_i | input | LEN_W | Number of bits in the load |
| mem_data_i | input | 1 | Serial data from the external memory |
| mem_rst_o | output | 1 | Reset to the external memory |
| mem_clk_o | output | 1 | Bit clock to the external memory |
| slave_data_i | input | 1 | Serial data in follower mode |
| slave_stb_i | input | 1 | Data strobe in follower mode |
| sdo_o | output | 1 | Bit pushed out of the selected chain |
| sdo_vld_o | output | 1 | Strobe for sdo_o |
| done_o | output | 1 | Configuration complete |
| err_o | output | 1 | Last start used an invalid mode code |
| reinit_i | input | 1 | Restore flip-flops to their stored values |
| ff_we_i | input | 1 | User write to the flip-flop bank |
| ff_wdata_i | input | NUM_CHAINS*FF_BITS | User write data |
| sw_close_o | output | NUM_CHAINS*SW_BITS | Switch controls, 1 = closed |
| ff_q_o | output | NUM_CHAINS*FF_BITS | User flip-flop outputs |

## Verification
Some rules hold on every cycle, and the assertions check these. Memory reset and memory clock are never high together. Every clock pulse lasts a single cycle. The bit count never goes past the latched length, and done implies the count has reached it. An error appears only while the loader is idle. A chain without a shift keeps its bits. The flip-flop bank holds unless it is reloaded or written. A reinit leaves the switch outputs unchanged. Other properties can only be shown by the bench scenarios, because they depend on a whole load. These cover the final contents of each chain against the bitstream order, the serial pass-through sequence, the exact pulse count, partial reprogramming that leaves the other chains alone, the masking during a load, and a busy-time start that has no effect.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

    localparam logic [2:0] MODE_DRIVE  = 3'b000;
    localparam logic [2:0] MODE_FOLLOW = 3'b111;

    typedef struct packed {
        logic drive;
        logic follow;
        logic bad;
    } mode_dec_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_MRST,
        SQ_MLOW,
        SQ_MHIGH,
        SQ_FOLLOW,
        SQ_DONE
    } seq_state_e;

    typedef struct packed {
        logic en;
        logic bit_in;
    } shift_req_t;

    function automatic mode_dec_t decode_mode(input logic [2:0] code);
        mode_dec_t d;
        d.drive  = (code == MODE_DRIVE);
        d.follow = (code == MODE_FOLLOW);
        d.bad    = !(d.drive || d.follow);
        return d;
    endfunction

endpackage

// File: rtl/cfg_mode_decode.sv
module cfg_mode_decode
    import cfg_loader_pkg::*;
(
    input  logic [2:0] code_i,
    output mode_dec_t  dec_o
);
    always_comb begin
        dec_o = decode_mode(code_i);
    end
endmodule

// File: rtl/cfg_load_seq.sv
module cfg_load_seq
    import cfg_loader_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  mode_dec_t        mode_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             mem_data_i,
    input  logic             slave_data_i,
    input  logic             slave_stb_i,
    output logic             mem_rst_o,
    output logic             mem_clk_o,
    output shift_req_t       shift_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o,
    output logic             enter_done_o
);
    seq_state_e       st_q, st_d;
    logic [LEN_W-1:0] cnt_q, cnt_d, len_q, len_d;
    logic             err_q, err_d;
    shift_req_t       sh;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        len_d = len_q;
        err_d = err_q;
        sh    = '0;
        case (st_q)
            SQ_IDLE, SQ_DONE: begin
                if (start_i) begin
                    cnt_d = '0;
                    len_d = len_i;
                    if (mode_i.drive) begin
                        st_d  = SQ_MRST;
                        err_d = 1'b0;
                    end else if (mode_i.follow) begin
                        st_d  = SQ_FOLLOW;
                        err_d = 1'b0;
                    end else begin
                        st_d  = SQ_IDLE;
                        err_d = 1'b1;
                    end
                end
            end
            SQ_MRST: st_d = SQ_MLOW;
            SQ_MLOW: begin
                if (cnt_q == len_q) begin
                    st_d = SQ_DONE;
                end else begin
                    sh.en     = 1'b1;
                    sh.bit_in = mem_data_i;
                    cnt_d     = cnt_q + 1'b1;
                    st_d      = SQ_MHIGH;
                end
            end
            SQ_MHIGH: st_d = SQ_MLOW;
            SQ_FOLLOW: begin
                if (cnt_q == len_q) begin
                    st_d = SQ_DONE;
                end else if (slave_stb_i) begin
                    sh.en     = 1'b1;
                    sh.bit_in = slave_data_i;
                    cnt_d     = cnt_q + 1'b1;
                end
            end
            default: st_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= SQ_IDLE;
            cnt_q <= '0;
            len_q <= '0;
            err_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            len_q <= len_d;
            err_q <= err_d;
        end
    end

    assign shift_o      = sh;
    assign mem_rst_o    = (st_q == SQ_MRST);
    assign mem_clk_o    = (st_q == SQ_MHIGH);
    assign busy_o       = !(st_q == SQ_IDLE || st_q == SQ_DONE);
    assign done_o       = (st_q == SQ_DONE);
    assign err_o        = err_q;
    assign enter_done_o = (st_d == SQ_DONE) && (st_q != SQ_DONE);

    // R3
    rst_clk_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_rst_o && mem_clk_o));
    // R3
    clk_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        mem_clk_o |=> !mem_clk_o);
    // R7
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= len_q);
    // R7
    done_count_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (cnt_q == len_q));
    // R2
    err_idle_chk: assert property (@(posedge clk) disable iff (rst)
        err_o |-> !busy_o && !done_o);
endmodule

// File: rtl/cfg_shift_chain.sv
module cfg_shift_chain #(
    parameter int LEN = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           shift_en_i,
    input  logic           sin_i,
    output logic [LEN-1:0] bits_o,
    output logic           sout_o
);
    logic [LEN-1:0] bits_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bits_q <= '0;
        end else if (shift_en_i) begin
            bits_q <= {bits_q[LEN-2:0], sin_i};
        end
    end

    assign bits_o = bits_q;
    assign sout_o = bits_q[LEN-1];

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !shift_en_i |=> $stable(bits_q));
endmodule

// File: rtl/cfg_user_flops.sv
module cfg_user_flops #(
    parameter int NUM_CHAINS = 4,
    parameter int FF_BITS    = 4,
    localparam int TOTAL     = NUM_CHAINS * FF_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reload_i,
    input  logic             we_i,
    input  logic [TOTAL-1:0] init_i,
    input  logic [TOTAL-1:0] wdata_i,
    output logic [TOTAL-1:0] q_o
);
    logic [TOTAL-1:0] q_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_q <= '0;
        end else if (reload_i) begin
            q_q <= init_i;
        end else if (we_i) begin
            q_q <= wdata_i;
        end
    end

    assign q_o = q_q;

    // R9
    ff_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!reload_i && !we_i) |=> $stable(q_q));
endmodule

// File: rtl/cfg_chain_loader.sv
module cfg_chain_loader
    import cfg_loader_pkg::*;
#(
    parameter int NUM_CHAINS = 4,
    parameter int CHAIN_LEN  = 16,
    parameter int FF_BITS    = 4,
    parameter int LEN_W      = 8,
    localparam int SEL_W     = (NUM_CHAINS > 1) ? $clog2(NUM_CHAINS) : 1,
    localparam int SW_BITS   = CHAIN_LEN - FF_BITS
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start_i,
    input  logic [2:0]                    mode_i,
    input  logic [SEL_W-1:0]              chain_sel_i,
    input  logic [LEN_W-1:0]              load_len_i,
    input  logic                          mem_data_i,
    output logic                          mem_rst_o,
    output logic                          mem_clk_o,
    input  logic                          slave_data_i,
    input  logic                          slave_stb_i,
    output logic                          sdo_o,
    output logic                          sdo_vld_o,
    output logic                          done_o,
    output logic                          err_o,
    input  logic                          reinit_i,
    input  logic                          ff_we_i,
    input  logic [NUM_CHAINS*FF_BITS-1:0] ff_wdata_i,
    output logic [NUM_CHAINS*SW_BITS-1:0] sw_close_o,
    output logic [NUM_CHAINS*FF_BITS-1:0] ff_q_o
);
    mode_dec_t  mode_dec;
    shift_req_t shift;
    logic       busy, done, enter_done;
    logic [SEL_W-1:0] sel_q;
    logic [CHAIN_LEN-1:0] chain_bits [NUM_CHAINS];
    logic [NUM_CHAINS-1:0] chain_sout;
    logic [NUM_CHAINS*FF_BITS-1:0] init_flat, ff_q;
    logic sdo_q, sdo_vld_q;

    cfg_mode_decode u_dec (
        .code_i (mode_i),
        .dec_o  (mode_dec)
    );

    cfg_load_seq #(.LEN_W(LEN_W)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .mode_i       (mode_dec),
        .len_i        (load_len_i),
        .mem_data_i   (mem_data_i),
        .slave_data_i (slave_data_i),
        .slave_stb_i  (slave_stb_i),
        .mem_rst_o    (mem_rst_o),
        .mem_clk_o    (mem_clk_o),
        .shift_o      (shift),
        .busy_o       (busy),
        .done_o       (done),
        .err_o        (err_o),
        .enter_done_o (enter_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
        end else if (start_i && !busy) begin
            sel_q <= chain_sel_i;
        end
    end

    for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_chain
        cfg_shift_chain #(.LEN(CHAIN_LEN)) u_chain (
            .clk        (clk),
            .rst        (rst),
            .shift_en_i (shift.en && (sel_q == SEL_W'(c))),
            .sin_i      (shift.bit_in),
            .bits_o     (chain_bits[c]),
            .sout_o     (chain_sout[c])
        );
        assign init_flat[c*FF_BITS +: FF_BITS] = chain_bits[c][FF_BITS-1:0];
        assign sw_close_o[c*SW_BITS +: SW_BITS] =
            done ? chain_bits[c][CHAIN_LEN-1:FF_BITS] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sdo_q     <= 1'b0;
            sdo_vld_q <= 1'b0;
        end else begin
            sdo_vld_q <= shift.en;
            if (shift.en) begin
                sdo_q <= chain_sout[sel_q];
            end
        end
    end

    cfg_user_flops #(.NUM_CHAINS(NUM_CHAINS), .FF_BITS(FF_BITS)) u_ff (
        .clk      (clk),
        .rst      (rst),
        .reload_i (enter_done || (done && reinit_i)),
        .we_i     (done && ff_we_i && !reinit_i),
        .init_i   (init_flat),
        .wdata_i  (ff_wdata_i),
        .q_o      (ff_q)
    );

    assign ff_q_o    = done ? ff_q : '0;
    assign done_o    = done;
    assign sdo_o     = sdo_q;
    assign sdo_vld_o = sdo_vld_q;

    // R9
    reinit_sw_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && reinit_i && !start_i) |=> $stable(sw_close_o));
    // R10
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start_i) |=> $stable(err_o) && $stable(sel_q));
endmodule

// File: tb/cfg_chain_loader_test.sv
module cfg_chain_loader_test;
    localparam int NC = 4, CL = 16, FB = 4, SB = CL - FB;

    logic clk = 0, rst = 1;
    logic start = 0, sdata = 0, sstb = 0, reinit = 0, ffwe = 0;
    logic [2:0] mode = 0;
    logic [1:0] sel = 0;
    logic [7:0] len = 0;
    logic [NC*FB-1:0] ffwd = 0;
    logic mem_rst, mem_clk, sdo, sdo_vld, done, err;
    logic [NC*SB-1:0] sw;
    logic [NC*FB-1:0] ffq;
    logic [63:0] strm = 0;
    int idx = 0;
    int checks = 0, fails = 0;
    logic [CL-1:0] mdl [NC];
    logic [FB-1:0] ffm [NC];
    logic [63:0] exp_out;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (mem_rst) idx <= 0;
        else if (mem_clk) idx <= idx + 1;
    end

    cfg_chain_loader uut (
        .clk(clk), .rst(rst), .start_i(start), .mode_i(mode), .chain_sel_i(sel),
        .load_len_i(len), .mem_data_i(strm[idx[5:0]]), .mem_rst_o(mem_rst),
        .mem_clk_o(mem_clk), .slave_data_i(sdata), .slave_stb_i(sstb),
        .sdo_o(sdo), .sdo_vld_o(sdo_vld), .done_o(done), .err_o(err),
        .reinit_i(reinit), .ff_we_i(ffwe), .ff_wdata_i(ffwd),
        .sw_close_o(sw), .ff_q_o(ffq)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [NC*SB-1:0] exp_sw();
        logic [NC*SB-1:0] v;
        for (int c = 0; c < NC; c++) v[c*SB +: SB] = mdl[c][CL-1:FB];
        return v;
    endfunction

    function automatic logic [NC*FB-1:0] exp_ff();
        logic [NC*FB-1:0] v;
        for (int c = 0; c < NC; c++) v[c*FB +: FB] = ffm[c];
        return v;
    endfunction

    task automatic make_stream(input int seed, input int n, input int s);
        for (int k = 0; k < 64; k++) strm[k] = 1'(((k * 7 + seed * 13 + k * k) >> 1) ^ (k >> 3));
        for (int k = 0; k < n; k++) begin
            exp_out[k] = mdl[s][CL-1];
            mdl[s] = {mdl[s][CL-2:0], strm[k]};
        end
    endtask

    task automatic finish_model();
        for (int c = 0; c < NC; c++) ffm[c] = mdl[c][FB-1:0];
        chk(sw == exp_sw(), "R5/R8 switch bits", longint'(sw), longint'(exp_sw()));
        chk(ffq == exp_ff(), "R9 flops loaded at done", longint'(ffq), longint'(exp_ff()));
    endtask

    task automatic drive_load(input int s, input int n, input int seed, input bit busy_poke);
        int pulses = 0, rsts = 0, nv = 0, cyc = 0;
        bit masked = 1;
        make_stream(seed, n, s);
        @(negedge clk);
        mode = 3'b000; sel = 2'(s); len = 8'(n); start = 1;
        @(negedge clk);
        start = 0;
        while (!done && cyc < 400) begin
            if (busy_poke && cyc == 5) begin
                start = 1; mode = 3'b101; sel = 2'(s + 1); len = 8'd3;
            end else begin
                start = 0;
            end
            if (mem_rst) rsts++;
            if (mem_clk) pulses++;
            if (sdo_vld) begin
                chk(sdo == exp_out[nv], "R6 pass-through bit", longint'(sdo), longint'(exp_out[nv]));
                nv++;
            end
            if (sw != 0 || ffq != 0) masked = 0;
            cyc++;
            @(negedge clk);
        end
        start = 0;
        chk(done, "R7 done raised", longint'(done), 1);
        chk(masked, "R8 outputs masked while loading", 0, 1);
        chk(pulses == n, "R3 memory clock pulses", pulses, n);
        chk(rsts == 1, "R3 single memory reset", rsts, 1);
        chk(nv == n, "R6 strobe count", nv, n);
        if (busy_poke) chk(!err, "R10 busy start ignored", longint'(err), 0);
        finish_model();
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int c = 0; c < NC; c++) begin mdl[c] = '0; ffm[c] = '0; end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(!done && !err && !mem_rst && !mem_clk && !sdo_vld, "R1 reset controls",
            longint'({done, err, mem_rst, mem_clk, sdo_vld}), 0);
        chk(sw == 0 && ffq == 0, "R1 reset outputs", longint'(sw), 0);

        // R5 every chain, full-length loads
        for (int s = 0; s < NC; s++) drive_load(s, CL, s + 1, 0);
        // R6 overlength load pushes old bits out
        drive_load(1, 20, 9, 0);
        // R5 partial load, other chains untouched
        drive_load(2, 5, 4, 0);
        // R7 zero length
        drive_load(3, 0, 2, 0);
        // R10 start during load
        drive_load(0, 12, 6, 1);

        // R4 follower load
        begin
            int n = 18, nv = 0;
            bit quiet = 1;
            make_stream(11, n, 3);
            @(negedge clk);
            mode = 3'b111; sel = 2'd3; len = 8'(n); start = 1;
            @(negedge clk);
            start = 0;
            for (int k = 0; k < n; k++) begin
                sstb = 1; sdata = strm[k];
                @(negedge clk);
                sstb = 0;
                if (mem_clk || mem_rst) quiet = 0;
                if (sdo_vld) begin
                    chk(sdo == exp_out[nv], "R6 follower pass-through", longint'(sdo), longint'(exp_out[nv]));
                    nv++;
                end
                @(negedge clk);
                if (mem_clk || mem_rst) quiet = 0;
            end
            repeat (2) @(negedge clk);
            chk(quiet, "R4 no memory activity", 0, 1);
            chk(nv == n, "R4 follower shift count", nv, n);
            chk(done, "R7 follower done", longint'(done), 1);
            finish_model();
        end

        // R9 user write then reinit
        @(negedge clk);
        ffwe = 1; ffwd = 16'hA5C3;
        @(negedge clk);
        ffwe = 0;
        chk(ffq == 16'hA5C3, "R9 user write", longint'(ffq), 16'hA5C3);
        reinit = 1;
        @(negedge clk);
        reinit = 0;
        chk(ffq == exp_ff(), "R9 reinit restores", longint'(ffq), longint'(exp_ff()));
        chk(sw == exp_sw(), "R9 switches kept", longint'(sw), longint'(exp_sw()));

        // R2 invalid codes
        for (int m = 1; m < 7; m++) begin
            bit act = 0;
            @(negedge clk);
            mode = 3'(m); start = 1;
            @(negedge clk);
            start = 0;
            for (int k = 0; k < 4; k++) begin
                if (mem_clk || mem_rst || done) act = 1;
                @(negedge clk);
            end
            chk(err && !act, "R2 invalid mode", longint'({err, act}), 2);
            chk(sw == 0 && ffq == 0, "R8 masked after error", longint'(sw), 0);
        end
        // R2 valid start clears error
        drive_load(0, 3, 5, 0);
        chk(!err, "R2 error cleared", longint'(err), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule